// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor core that retires one instruction per clock. In every cycle it fetches a 32-bit instruction word from a local instruction array at the program counter. It decodes the word as register, immediate or jump format, reads two general registers and computes a result or an address. It then updates the register file, the data array and the program counter on the closing clock edge. The core supports register add, subtract and signed set-less-than, immediate add, word and byte loads and stores, equal and not-equal branches, absolute jumps, jump-and-link and jump-to-register.

Both arrays are word-organised. The data array is split into four byte lanes so that a byte store touches one lane only. Byte numbering is big-endian. While the reset input is high, a debug port loads programs and data into the arrays. The same port reads back a chosen general register, a chosen data word and the program counter, so the core state can be seen at its pins.

Top module: `cpu_core`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter becomes 0 and all 32 general registers become 0.
- R2: add (opcode 0, funct 32), sub (opcode 0, funct 34) and addi (opcode 8, 16-bit immediate sign-extended) write the 32-bit two's-complement sum or difference to rd (register format) or rt (immediate format).
- R3: slt (opcode 0, funct 42) writes 1 to rd when rs is less than rt as signed numbers, otherwise 0.
- R4: Register 0 reads as zero at all times; writes aimed at it have no effect.
- R5: lw (opcode 35) and sw (opcode 43) move a whole word at byte address rs + sign-extended immediate; a negative offset is allowed.
- R6: lb (opcode 32) reads one byte at that address, big-endian: byte offset 0 is bits [31:24] and offset 3 is bits [7:0]. The byte is sign-extended into rt.
- R7: sb (opcode 40) writes the low byte of rt into the addressed lane only; the word's other three bytes keep their values.
- R8: beq (opcode 4) and bne (opcode 5) go to PC+4 + (sign-extended immediate * 4) when their condition holds, otherwise to PC+4.
- R9: j (opcode 2) and jal (opcode 3) go to {PC+4 bits [31:28], 26-bit target, 2'b00}.
- R10: jal also writes PC+4 into register 31.
- R11: jr (opcode 0, funct 8) loads the program counter from rs.
- R12: Any other opcode, or opcode 0 with any other funct, changes no register and no memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset; also blocks core stores |
| imem_we | input | 1 | Writes `dbg_wdata` into instruction word `dbg_addr` |
| dmem_we | input | 1 | Writes `dbg_wdata` into data word `dbg_addr` |
| dbg_addr | input | AW (6) | Word index for debug writes and the data read-back |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rsel | input | 5 | General register selected for read-back |
| dbg_rdata | output | 32 | Current value of register `dbg_rsel` |
| dbg_mdata | output | 32 | Current value of data word `dbg_addr` |
| pc_o | output | 32 | Current program counter |

## Verification
Each instruction's effect on a register, a data word or the program counter appears just after the rising edge that ends its own cycle. The register and data read-back ports are combinational, so a value written at an edge can be read one time step later. Each directed program therefore ends in a branch-to-self loop, and the bench runs a fixed number of cycles that is well past the last useful instruction. All values are sampled one time unit after an edge, when the inputs and outputs are stable. Reset is checked by raising `rst` for one edge and reading the PC and a register that had been written.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_J     = 6'd2;
    localparam logic [5:0] OP_JAL   = 6'd3;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_BNE   = 6'd5;
    localparam logic [5:0] OP_ADDI  = 6'd8;
    localparam logic [5:0] OP_LB    = 6'd32;
    localparam logic [5:0] OP_LW    = 6'd35;
    localparam logic [5:0] OP_SB    = 6'd40;
    localparam logic [5:0] OP_SW    = 6'd43;

    localparam logic [5:0] FN_JR  = 6'd8;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_SLT = 6'd42;

    localparam logic [REG_AW-1:0] LINK_REG = 5'd31;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT} alu_op_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;
    typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_sel_e;
    typedef enum logic [2:0] {NX_SEQ, NX_BEQ, NX_BNE, NX_JUMP, NX_JREG} nx_sel_e;

    typedef struct packed {
        logic [5:0]        op;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } ins_fields_t;

    typedef struct packed {
        logic     reg_we;
        dst_sel_e dst;
        wb_sel_e  wb;
        alu_op_e  alu;
        logic     use_imm;
        logic     mem_wr;
        logic     byte_acc;
        nx_sel_e  nx;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext8(input logic [7:0] v);
        return {{(XLEN-8){v[7]}}, v};
    endfunction

    // big-endian lane pick: offset 0 is the most significant byte
    function automatic logic [7:0] lane_byte(input logic [XLEN-1:0] w, input logic [1:0] off);
        case (off)
            2'd0:    return w[31:24];
            2'd1:    return w[23:16];
            2'd2:    return w[15:8];
            default: return w[7:0];
        endcase
    endfunction

endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import cpu_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int AW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   ra1,
    output logic [XLEN-1:0] rd1,
    input  logic [AW-1:0]   ra2,
    output logic [XLEN-1:0] rd2,
    input  logic [AW-1:0]   ra3,
    output logic [XLEN-1:0] rd3
);

    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
    assign rd3 = regs[ra3];

    AST_REG0_STAYS_ZERO: assert property (@(posedge clk) disable iff (rst)
        regs[0] == '0); // R4

endmodule

// File: rtl/cpu_decode.sv
module cpu_decode
    import cpu_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);

    ins_fields_t f;
    logic        unused_shamt;

    assign f = ins_fields_t'(instr);
    assign unused_shamt = ^f.shamt;

    always_comb begin
        ctrl     = '0;
        ctrl.dst = DST_RT;
        ctrl.wb  = WB_ALU;
        ctrl.alu = ALU_ADD;
        ctrl.nx  = NX_SEQ;
        case (f.op)
            OP_RTYPE: begin
                ctrl.dst = DST_RD;
                case (f.funct)
                    FN_ADD: ctrl.reg_we = 1'b1;
                    FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SUB; end
                    FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SLT; end
                    FN_JR:  ctrl.nx = NX_JREG;
                    default: ;
                endcase
            end
            OP_ADDI: begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; end
            OP_LW: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.wb = WB_MEM;
            end
            OP_LB: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.wb = WB_MEM;
                ctrl.byte_acc = 1'b1;
            end
            OP_SW: begin ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1; end
            OP_SB: begin
                ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1; ctrl.byte_acc = 1'b1;
            end
            OP_BEQ: begin ctrl.alu = ALU_SUB; ctrl.nx = NX_BEQ; end
            OP_BNE: begin ctrl.alu = ALU_SUB; ctrl.nx = NX_BNE; end
            OP_J:   ctrl.nx = NX_JUMP;
            OP_JAL: begin
                ctrl.nx = NX_JUMP; ctrl.reg_we = 1'b1;
                ctrl.dst = DST_LINK; ctrl.wb = WB_LINK;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            eq
);

    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign eq = (a == b);

endmodule

// File: rtl/cpu_dmem.sv
module cpu_dmem
    import cpu_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int AW = $clog2(WORDS),
    localparam int LANES = XLEN / 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW+1:0]   addr,
    input  logic [XLEN-1:0] wdata,
    input  logic            wr_en,
    input  logic            byte_mode,
    output logic [XLEN-1:0] rdata,
    input  logic            dbg_we,
    input  logic [AW-1:0]   dbg_addr,
    input  logic [XLEN-1:0] dbg_wdata,
    output logic [XLEN-1:0] dbg_rdata
);

    logic [AW-1:0]    word_idx;
    logic [LANES-1:0] lane_we;

    assign word_idx = addr[AW+1:2];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int HI = XLEN - 1 - 8 * g;
        logic [7:0] bytes_q [WORDS];

        // lane g holds byte offset g (big-endian)
        assign lane_we[g] = wr_en && (!byte_mode || (addr[1:0] == 2'(g)));

        always_ff @(posedge clk) begin
            if (dbg_we) begin
                bytes_q[dbg_addr] <= dbg_wdata[HI -: 8];
            end else if (lane_we[g]) begin
                bytes_q[word_idx] <= byte_mode ? wdata[7:0] : wdata[HI -: 8];
            end
        end

        assign rdata[HI -: 8]     = bytes_q[word_idx];
        assign dbg_rdata[HI -: 8] = bytes_q[dbg_addr];
    end

    AST_BYTE_STORE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && byte_mode) |-> $countones(lane_we) == 1); // R7

    AST_WORD_STORE_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !byte_mode) |-> $countones(lane_we) == LANES); // R5

endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    localparam int AW = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              imem_we,
    input  logic              dmem_we,
    input  logic [AW-1:0]     dbg_addr,
    input  logic [XLEN-1:0]   dbg_wdata,
    input  logic [REG_AW-1:0] dbg_rsel,
    output logic [XLEN-1:0]   dbg_rdata,
    output logic [XLEN-1:0]   dbg_mdata,
    output logic [XLEN-1:0]   pc_o
);

    logic [XLEN-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
    logic [XLEN-1:0] instr, imm, rs_val, rt_val, alu_b, alu_y;
    logic [XLEN-1:0] mem_word, load_val, wb_data;
    logic [REG_AW-1:0] wb_addr;
    logic            eq, store_en;
    ins_fields_t     f;
    ctrl_t           ctrl;

    // instruction fetch
    always_ff @(posedge clk) begin
        if (imem_we) imem[dbg_addr] <= dbg_wdata;
    end
    assign instr = imem[pc_q[AW+1:2]];
    assign f     = ins_fields_t'(instr);
    assign imm   = sext16(instr[15:0]);

    cpu_decode u_dec (.instr(instr), .ctrl(ctrl));

    cpu_regfile #(.NREGS(1 << REG_AW)) u_rf (
        .clk(clk), .rst(rst),
        .we(ctrl.reg_we), .waddr(wb_addr), .wdata(wb_data),
        .ra1(f.rs), .rd1(rs_val),
        .ra2(f.rt), .rd2(rt_val),
        .ra3(dbg_rsel), .rd3(dbg_rdata)
    );

    assign alu_b = ctrl.use_imm ? imm : rt_val;

    cpu_alu u_alu (.a(rs_val), .b(alu_b), .op(ctrl.alu), .y(alu_y), .eq(eq));

    assign store_en = ctrl.mem_wr && !rst;

    cpu_dmem #(.WORDS(MEM_WORDS)) u_dmem (
        .clk(clk), .rst(rst),
        .addr(alu_y[AW+1:0]), .wdata(rt_val),
        .wr_en(store_en), .byte_mode(ctrl.byte_acc),
        .rdata(mem_word),
        .dbg_we(dmem_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_rdata(dbg_mdata)
    );

    assign load_val = ctrl.byte_acc ? sext8(lane_byte(mem_word, alu_y[1:0])) : mem_word;

    // write-back selection
    always_comb begin
        case (ctrl.dst)
            DST_RD:   wb_addr = f.rd;
            DST_LINK: wb_addr = LINK_REG;
            default:  wb_addr = f.rt;
        endcase
        case (ctrl.wb)
            WB_MEM:  wb_data = load_val;
            WB_LINK: wb_data = pc_plus4;
            default: wb_data = alu_y;
        endcase
    end

    // next program counter
    assign pc_plus4 = pc_q + 32'd4;
    assign br_tgt   = pc_plus4 + {imm[XLEN-3:0], 2'b00};
    assign jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        case (ctrl.nx)
            NX_BEQ:  pc_next = eq ? br_tgt : pc_plus4;
            NX_BNE:  pc_next = eq ? pc_plus4 : br_tgt;
            NX_JUMP: pc_next = jmp_tgt;
            NX_JREG: pc_next = rs_val;
            default: pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o = pc_q;

    AST_PLAIN_STEP_BY_FOUR: assert property (@(posedge clk) disable iff (rst)
        (ctrl.nx == NX_SEQ) |=> pc_q == $past(pc_q) + 32'd4); // R12

    AST_BEQ_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
        (f.op == OP_BEQ && rs_val == rt_val)
            |=> pc_q == $past(pc_q) + 32'd4 + ($past(imm) << 2)); // R8

    AST_BNE_FALLTHROUGH: assert property (@(posedge clk) disable iff (rst)
        (f.op == OP_BNE && rs_val == rt_val) |=> pc_q == $past(pc_q) + 32'd4); // R8

    AST_JUMP_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (f.op == OP_J || f.op == OP_JAL)
            |=> pc_q[27:0] == {$past(instr[25:0]), 2'b00}); // R9

    AST_JR_FROM_RS: assert property (@(posedge clk) disable iff (rst)
        (f.op == OP_RTYPE && f.funct == FN_JR) |=> pc_q == $past(rs_val)); // R11

    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> pc_q == '0); // R1

endmodule

// File: tb/cpu_core_test.sv
module cpu_core_test;

    localparam int CLK_P = 10;
    localparam int AW    = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_we = 1'b0;
    logic        dmem_we = 1'b0;
    logic [AW-1:0] dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic [4:0]  dbg_rsel = '0;
    logic [31:0] dbg_rdata, dbg_mdata, pc_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] prog [32];
    int np = 0;

    cpu_core #(.MEM_WORDS(64)) uut (
        .clk(clk), .rst(rst), .imem_we(imem_we), .dmem_we(dmem_we),
        .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rsel(dbg_rsel),
        .dbg_rdata(dbg_rdata), .dbg_mdata(dbg_mdata), .pc_o(pc_o)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [31:0] r_ins(input logic [5:0] fn, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [4:0] rd);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] i_ins(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] im);
        return {op, rs, rt, im};
    endfunction

    function automatic logic [31:0] j_ins(input logic [5:0] op, input logic [25:0] t);
        return {op, t};
    endfunction

    localparam logic [31:0] HALT = {6'd4, 5'd0, 5'd0, 16'hFFFF};

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [4:0] r, input logic [31:0] exp);
        dbg_rsel = r;
        #1;
        chk(req, $sformatf("reg %0d", r), dbg_rdata, exp);
    endtask

    task automatic chk_mem(input string req, input int w, input logic [31:0] exp);
        dbg_addr = AW'(w);
        #1;
        chk(req, $sformatf("dmem word %0d", w), dbg_mdata, exp);
    endtask

    task automatic begin_prog();
        rst = 1'b1;
        np = 0;
        @(posedge clk); #1;
    endtask

    task automatic emit(input logic [31:0] w);
        prog[np] = w;
        np++;
    endtask

    task automatic poke(input int w, input logic [31:0] d);
        dmem_we = 1'b1; dbg_addr = AW'(w); dbg_wdata = d;
        @(posedge clk); #1;
        dmem_we = 1'b0;
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < np; i++) begin
            imem_we = 1'b1; dbg_addr = AW'(i); dbg_wdata = prog[i];
            @(posedge clk); #1;
        end
        imem_we = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
        repeat (cycles) @(posedge clk);
        #1;
    endtask

    task automatic t_arith();
        begin_prog();
        emit(i_ins(6'd8, 5'd0, 5'd1, 16'd5));
        emit(i_ins(6'd8, 5'd0, 5'd2, 16'hFFFD));
        emit(r_ins(6'd32, 5'd1, 5'd2, 5'd3));
        emit(r_ins(6'd34, 5'd2, 5'd1, 5'd4));
        emit(r_ins(6'd42, 5'd2, 5'd1, 5'd5));
        emit(r_ins(6'd42, 5'd1, 5'd2, 5'd6));
        emit(r_ins(6'd32, 5'd2, 5'd2, 5'd8));
        emit(i_ins(6'd8, 5'd0, 5'd0, 16'd7));
        emit(r_ins(6'd32, 5'd0, 5'd0, 5'd9));
        emit(HALT);
        run(16);
        chk_reg("R2", 5'd2, 32'hFFFF_FFFD);
        chk_reg("R2", 5'd3, 32'd2);
        chk_reg("R2", 5'd4, 32'hFFFF_FFF8);
        chk_reg("R2", 5'd8, 32'hFFFF_FFFA);
        chk_reg("R3", 5'd5, 32'd1);
        chk_reg("R3", 5'd6, 32'd0);
        chk_reg("R4", 5'd0, 32'd0);
        chk_reg("R4", 5'd9, 32'd0);
        chk("R8", "pc at self loop", pc_o, 32'd36);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R1", "pc after reset", pc_o, 32'd0);
        chk_reg("R1", 5'd3, 32'd0);
        chk_reg("R1", 5'd2, 32'd0);
    endtask

    task automatic t_memory();
        begin_prog();
        poke(1, 32'h80FF_7F01);
        poke(2, 32'h0000_0000);
        poke(3, 32'hAABB_CCDD);
        emit(i_ins(6'd8,  5'd0, 5'd1, 16'd4));
        emit(i_ins(6'd35, 5'd1, 5'd2, 16'd0));
        emit(i_ins(6'd32, 5'd1, 5'd3, 16'd0));
        emit(i_ins(6'd32, 5'd1, 5'd4, 16'd2));
        emit(i_ins(6'd32, 5'd1, 5'd5, 16'd1));
        emit(i_ins(6'd8,  5'd0, 5'd6, 16'd12));
        emit(i_ins(6'd35, 5'd6, 5'd7, 16'hFFF8));
        emit(i_ins(6'd43, 5'd0, 5'd2, 16'd8));
        emit(i_ins(6'd40, 5'd0, 5'd1, 16'd13));
        emit(HALT);
        run(16);
        chk_reg("R5", 5'd2, 32'h80FF_7F01);
        chk_reg("R5", 5'd7, 32'h80FF_7F01);
        chk_reg("R6", 5'd3, 32'hFFFF_FF80);
        chk_reg("R6", 5'd4, 32'h0000_007F);
        chk_reg("R6", 5'd5, 32'hFFFF_FFFF);
        chk_mem("R5", 2, 32'h80FF_7F01);
        chk_mem("R7", 3, 32'hAA04_CCDD);
        chk_mem("R7", 1, 32'h80FF_7F01);
    endtask

    task automatic t_branch();
        begin_prog();
        emit(i_ins(6'd8, 5'd0, 5'd1, 16'd1));
        emit(i_ins(6'd4, 5'd1, 5'd0, 16'd1));
        emit(i_ins(6'd8, 5'd0, 5'd2, 16'd7));
        emit(i_ins(6'd5, 5'd1, 5'd0, 16'd1));
        emit(i_ins(6'd8, 5'd0, 5'd3, 16'd9));
        emit(i_ins(6'd8, 5'd0, 5'd4, 16'd4));
        emit(HALT);
        run(12);
        chk_reg("R8", 5'd2, 32'd7);
        chk_reg("R8", 5'd3, 32'd0);
        chk_reg("R8", 5'd4, 32'd4);
        chk("R8", "pc held by backward branch", pc_o, 32'd24);
    endtask

    task automatic t_jal_jr();
        begin_prog();
        emit(j_ins(6'd3, 26'd4));
        emit(i_ins(6'd8, 5'd0, 5'd5, 16'd1));
        emit(HALT);
        emit(i_ins(6'd8, 5'd0, 5'd6, 16'd1));
        emit(i_ins(6'd8, 5'd0, 5'd7, 16'd2));
        emit(r_ins(6'd8, 5'd31, 5'd0, 5'd0));
        run(12);
        chk_reg("R10", 5'd31, 32'd4);
        chk_reg("R9", 5'd7, 32'd2);
        chk_reg("R9", 5'd6, 32'd0);
        chk_reg("R11", 5'd5, 32'd1);
        chk("R11", "pc after return", pc_o, 32'd8);
    endtask

    task automatic t_jump();
        begin_prog();
        emit(j_ins(6'd2, 26'd3));
        emit(i_ins(6'd8, 5'd0, 5'd1, 16'd1));
        emit(i_ins(6'd8, 5'd0, 5'd2, 16'd1));
        emit(HALT);
        run(8);
        chk("R9", "pc after j", pc_o, 32'd12);
        chk_reg("R9", 5'd1, 32'd0);
        chk_reg("R9", 5'd2, 32'd0);
    endtask

    task automatic t_unknown();
        begin_prog();
        poke(0, 32'h1234_5678);
        emit(32'hFC22_0001);
        emit(r_ins(6'h3F, 5'd1, 5'd1, 5'd2));
        emit(i_ins(6'd6, 5'd0, 5'd3, 16'd0));
        emit(i_ins(6'd8, 5'd0, 5'd4, 16'd3));
        emit(HALT);
        run(10);
        chk_reg("R12", 5'd1, 32'd0);
        chk_reg("R12", 5'd2, 32'd0);
        chk_reg("R12", 5'd3, 32'd0);
        chk_reg("R12", 5'd4, 32'd3);
        chk_mem("R12", 0, 32'h1234_5678);
        chk("R12", "pc after unknown codes", pc_o, 32'd16);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "pc while in reset", pc_o, 32'd0);
        t_arith();
        t_reset();
        t_memory();
        t_branch();
        t_jal_jr();
        t_jump();
        t_unknown();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule